// File: doc/BRIEF.md
# Power-Managed ADC Frame Sequencer

This block is the host-side driver for a 12-bit serial converter that is kept in an automatic low-power state between samples. Each accepted sample request makes the block drive the converter's frame-sync, serial clock and data-in lines. When the chosen power mode sends the converter to sleep after every conversion, the block first runs a wake-up frame. That frame leaves the converter's control register alone. The block then runs the conversion frame whose returned word is kept. In the other power modes a single frame is enough.

Software sets the power-mode pair, the channel, the write-enable bit and the idle gap through plain configuration pins. The block reads them once, when it accepts a request. The word returned by the kept frame is split into a channel identifier and a 12-bit result. Both come out on a valid/ready result stream.

Back-pressure rules: a result stays on `res_valid`/`res_chan`/`res_data`, unchanged, until `res_ready` is seen high at a clock edge. `req_ready` stays low while a request is in progress (frames and trailing gap) and while a result waits to be taken. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.

Top module: `adc_frame_seq`

## Requirements
- R1: A frame starts when `adc_sync_n` falls and contains exactly 16 rising edges of `adc_sclk`. `adc_sync_n` rises one half period after the 16th rising edge. `adc_sclk` is high whenever `adc_sync_n` is high.
- R2: The block shifts a 12-bit control word out MSB first on `adc_sdi`. It changes `adc_sdi` on the falling edges of `adc_sclk` and the converter samples it on the rising edges. Bit 11 is the write bit, bits 10:9 are the power-mode pair (PM1,PM0), bits 8:7 are the channel and bits 6:0 are zero. During serial clocks 13 to 16 of a frame `adc_sdi` is 0.
- R3: Power modes 00 (auto standby) and 01 (auto shutdown) make each request run two frames. The first frame is a wake-up frame with write bit 0. Its other fields equal those of the second frame.
- R4: Power modes 10 and 11 make each request run one frame. That frame's write bit equals `cfg_write`.
- R5: `adc_sdo` is sampled on each rising edge of `adc_sclk`, MSB first, into a 16-bit word. `res_chan` is word bits 13:12 and `res_data` is word bits 11:0. Bits 15:14 are ignored.
- R6: Each request produces exactly one result, taken from the last frame of the request. The word returned during a wake-up frame is discarded.
- R7: Between any two frames, `adc_sync_n` stays high for at least 2·DIV·max(`cfg_gap`,1) system clocks. Here `cfg_gap` is the value latched with the request that ran the earlier frame.
- R8: The result is held stable while `res_valid` is high and `res_ready` is low. `res_valid` clears after the transfer. `req_ready` is low while `res_valid` is high. After reset `adc_sync_n` and `adc_sclk` are high, `res_valid` is low and `req_ready` is high.
- R9: Within a frame every half period of `adc_sclk` lasts exactly DIV system clocks.
- R10: The configuration pins are sampled only on the accepting edge. Changing them during a request has no effect on that request's frames or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pm | input | 2 | Power-mode pair PM1,PM0 |
| cfg_chan | input | 2 | Channel to convert |
| cfg_write | input | 1 | Write bit for the conversion frame |
| cfg_gap | input | 8 | Idle gap in serial clock periods (0 treated as 1) |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Request can be accepted |
| adc_sync_n | output | 1 | Frame-sync to converter, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdi | output | 1 | Serial data to converter |
| adc_sdo | input | 1 | Serial data from converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_chan | output | 2 | Channel identifier from the returned word |
| res_data | output | 12 | Conversion result |

## Verification
The in-line properties check these on every cycle: the count of 16 clock rises per frame, a high idle clock outside frames, the exact half-period spacing, the minimum high time of frame-sync between frames, a zero write bit at the start of each wake-up frame, result stability under back-pressure and the blocked request port. Only the bench scenarios can show the rest. These are the per-mode frame count, the full control word contents, which frame's returned word becomes the result, and that configuration changes after acceptance are ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int PM_W = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FRAME = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_t;

  // Power modes with a zero upper bit put the converter to sleep after each
  // conversion, so a wake-up frame must precede the kept one.
  function automatic logic needs_wake(input logic [PM_W-1:0] pm);
    return !pm[PM_W-1];
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || clr) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && !clr && (cnt == LAST);

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 12,
  parameter int KEEP_BITS  = 14,
  parameter int DIV        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic [CTRL_BITS-1:0] ctrl_word,
  input  logic                 sdo,
  output logic                 sync_n,
  output logic                 sclk,
  output logic                 sdi,
  output logic                 busy,
  output logic                 done,
  output logic [KEEP_BITS-1:0] word
);
  localparam int PHW = $clog2(2 * FRAME_BITS + 1);
  localparam logic [PHW-1:0] PH_END = PHW'(2 * FRAME_BITS);
  localparam logic [PHW-1:0] CTRL_LIM = PHW'(CTRL_BITS);

  logic [PHW-1:0]       ph;
  logic [CTRL_BITS-1:0] sh;
  logic [PHW-1:0]       bit_pos;
  logic                 in_ctrl;

  assign bit_pos = {1'b0, ph[PHW-1:1]};
  assign in_ctrl = (bit_pos < CTRL_LIM);

  // Half-period phase: even phases drop the clock and launch a bit,
  // odd phases raise it and capture the converter's bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_n <= 1'b1;
      sclk   <= 1'b1;
      sdi    <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      ph     <= '0;
      sh     <= '0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sync_n <= 1'b0;
        sclk   <= 1'b1;
        sdi    <= 1'b0;
        busy   <= 1'b1;
        ph     <= '0;
        sh     <= ctrl_word;
      end else if (busy && tick) begin
        if (ph == PH_END) begin
          sync_n <= 1'b1;
          busy   <= 1'b0;
          done   <= 1'b1;
          sdi    <= 1'b0;
        end else if (!ph[0]) begin
          sclk <= 1'b0;
          if (in_ctrl) begin
            sdi <= sh[CTRL_BITS-1];
            sh  <= {sh[CTRL_BITS-2:0], 1'b0};
          end else begin
            sdi <= 1'b0;
          end
        end else begin
          sclk <= 1'b1;
          word <= {word[KEEP_BITS-2:0], sdo};
        end
        ph <= ph + 1'b1;
      end
    end
  end

  // Pin-level observers for the frame shape properties.
  logic        sclk_q;
  logic        sync_q;
  logic [7:0]  rise_cnt;
  logic [15:0] hp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      sync_q   <= 1'b1;
      rise_cnt <= '0;
      hp_cnt   <= '0;
    end else begin
      sclk_q <= sclk;
      sync_q <= sync_n;
      if (sync_q && !sync_n) rise_cnt <= '0;
      else if (!sclk_q && sclk) rise_cnt <= rise_cnt + 1'b1;
      if (sclk_q != sclk) hp_cnt <= '0;
      else if (hp_cnt != 16'hFFFF) hp_cnt <= hp_cnt + 1'b1;
    end
  end

  assert_frame_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (rise_cnt == 8'(FRAME_BITS)));

  assert_sclk_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);

  assert_half_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && (sclk_q != sclk) && (sclk || rise_cnt != 8'd0)) |-> (hp_cnt == 16'(DIV - 1)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CTRL_BITS = 12,
  parameter int CHAN_BITS = 2,
  parameter int GAP_W     = 8,
  parameter int DIV       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PM_W-1:0]      cfg_pm,
  input  logic [CHAN_BITS-1:0] cfg_chan,
  input  logic                 cfg_write,
  input  logic [GAP_W-1:0]     cfg_gap,
  input  logic                 res_pending,
  input  logic                 tick,
  input  logic                 done,
  input  logic                 sync_n,
  output logic                 start,
  output logic [CTRL_BITS-1:0] ctrl_word,
  output logic                 div_en,
  output logic                 capture,
  output logic                 in_wake
);
  localparam int PAD_BITS = CTRL_BITS - 1 - PM_W - CHAN_BITS;
  localparam int GL_W     = GAP_W + 1;

  seq_state_t           state;
  logic [PM_W-1:0]      lat_pm;
  logic [CHAN_BITS-1:0] lat_chan;
  logic                 lat_wr;
  logic [GAP_W-1:0]     lat_gap;
  logic [GL_W-1:0]      gap_left;
  logic [GL_W-1:0]      gap_need;
  logic [GL_W-1:0]      gap_load;
  logic [GAP_W-1:0]     gap_eff;
  logic                 accept;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state == SEQ_IDLE) && !res_pending;
  assign div_en    = (state != SEQ_IDLE);
  assign capture   = (state == SEQ_FRAME) && done && !in_wake;
  assign gap_eff   = (lat_gap == '0) ? GAP_W'(1) : lat_gap;
  assign gap_load  = {gap_eff, 1'b0};
  assign ctrl_word = {(in_wake ? 1'b0 : lat_wr), lat_pm, lat_chan, {PAD_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      start    <= 1'b0;
      in_wake  <= 1'b0;
      lat_pm   <= '0;
      lat_chan <= '0;
      lat_wr   <= 1'b0;
      lat_gap  <= '0;
      gap_left <= '0;
      gap_need <= '0;
    end else begin
      start <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            lat_pm   <= cfg_pm;
            lat_chan <= cfg_chan;
            lat_wr   <= cfg_write;
            lat_gap  <= cfg_gap;
            in_wake  <= needs_wake(cfg_pm);
            start    <= 1'b1;
            state    <= SEQ_FRAME;
          end
        end
        SEQ_FRAME: begin
          if (done) begin
            gap_left <= gap_load - 1'b1;
            gap_need <= gap_load;
            state    <= SEQ_GAP;
          end
        end
        SEQ_GAP: begin
          if (tick) begin
            if (gap_left == '0) begin
              if (in_wake) begin
                in_wake <= 1'b0;
                start   <= 1'b1;
                state   <= SEQ_FRAME;
              end else begin
                state <= SEQ_IDLE;
              end
            end else begin
              gap_left <= gap_left - 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Cycles frame-sync has been high, saturating; starts saturated so the
  // first frame after reset is not mistaken for a short gap.
  logic [19:0] high_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) high_cnt <= '1;
    else if (!sync_n) high_cnt <= '0;
    else if (high_cnt != '1) high_cnt <= high_cnt + 1'b1;
  end

  assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (high_cnt >= 20'(gap_need) * 20'(DIV)));

  assert_req_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_pending |-> !req_ready);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int DIV        = 2,
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 12,
  parameter int RES_BITS   = 12,
  parameter int CHAN_BITS  = 2,
  parameter int GAP_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_pm,
  input  logic [CHAN_BITS-1:0] cfg_chan,
  input  logic                 cfg_write,
  input  logic [GAP_W-1:0]     cfg_gap,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic                 adc_sync_n,
  output logic                 adc_sclk,
  output logic                 adc_sdi,
  input  logic                 adc_sdo,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [CHAN_BITS-1:0] res_chan,
  output logic [RES_BITS-1:0]  res_data
);
  localparam int KEEP_BITS = RES_BITS + CHAN_BITS;

  logic                 tick;
  logic                 start;
  logic                 done;
  logic                 busy;
  logic                 div_en;
  logic                 capture;
  logic                 in_wake;
  logic [CTRL_BITS-1:0] ctrl_word;
  logic [KEEP_BITS-1:0] eng_word;

  adc_seq_ctrl #(
    .CTRL_BITS(CTRL_BITS), .CHAN_BITS(CHAN_BITS), .GAP_W(GAP_W), .DIV(DIV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_pm(cfg_pm), .cfg_chan(cfg_chan), .cfg_write(cfg_write), .cfg_gap(cfg_gap),
    .res_pending(res_valid), .tick(tick), .done(done), .sync_n(adc_sync_n),
    .start(start), .ctrl_word(ctrl_word), .div_en(div_en), .capture(capture),
    .in_wake(in_wake)
  );

  adc_sclk_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en), .clr(start), .tick(tick)
  );

  adc_frame_engine #(
    .FRAME_BITS(FRAME_BITS), .CTRL_BITS(CTRL_BITS), .KEEP_BITS(KEEP_BITS), .DIV(DIV)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .ctrl_word(ctrl_word),
    .sdo(adc_sdo), .sync_n(adc_sync_n), .sclk(adc_sclk), .sdi(adc_sdi),
    .busy(busy), .done(done), .word(eng_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else if (capture) begin
      res_valid <= 1'b1;
      res_chan  <= eng_word[KEEP_BITS-1:RES_BITS];
      res_data  <= eng_word[RES_BITS-1:0];
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // Observers for the wake-frame write bit at the pins.
  logic sclk_q;
  logic sync_q;
  logic first_fall;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      sync_q     <= 1'b1;
      first_fall <= 1'b0;
    end else begin
      sclk_q <= adc_sclk;
      sync_q <= adc_sync_n;
      if (sync_q && !adc_sync_n) first_fall <= 1'b1;
      else if (sclk_q && !adc_sclk) first_fall <= 1'b0;
    end
  end

  assert_wake_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake && first_fall && sclk_q && !adc_sclk) |-> !adc_sdi);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !res_valid);

  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

  assert_engine_idle_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_pm = 2'b00;
  logic [1:0] cfg_chan = 2'b00;
  logic cfg_write = 1'b0;
  logic [7:0] cfg_gap = 8'd1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic adc_sync_n, adc_sclk, adc_sdi;
  logic adc_sdo = 1'b0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [1:0] res_chan;
  logic [11:0] res_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  adc_frame_seq #(.DIV(DIV)) u_adc_frame_seq (
    .clk(clk), .rst_n(rst_n), .cfg_pm(cfg_pm), .cfg_chan(cfg_chan),
    .cfg_write(cfg_write), .cfg_gap(cfg_gap), .req_valid(req_valid),
    .req_ready(req_ready), .adc_sync_n(adc_sync_n), .adc_sclk(adc_sclk),
    .adc_sdi(adc_sdi), .adc_sdo(adc_sdo), .res_valid(res_valid),
    .res_ready(res_ready), .res_chan(res_chan), .res_data(res_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R8 watchdog expired: cycles=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Converter model and pin recorder.
  logic [15:0] cur_word;
  logic [15:0] sdi_bits;
  logic [15:0] wlog [4];
  logic [15:0] slog [4];
  int rlog [4];
  longint glog [4];
  int nfr = 0;
  int fall_n = 0;
  int rise_n = 0;
  int hp_bad = 0;
  bit in_frame = 0;
  time last_edge = 0;
  time last_sync_rise = 0;

  always @(negedge adc_sync_n) begin
    cur_word = 16'($urandom);
    fall_n = 0;
    rise_n = 0;
    sdi_bits = '0;
    in_frame = 1;
    if (nfr < 4) glog[nfr] = longint'((($time - last_sync_rise) / CLK_PERIOD));
  end

  always @(negedge adc_sclk) begin
    if (in_frame) begin
      if (rise_n > 0 && ($time - last_edge) != DIV * CLK_PERIOD) hp_bad = hp_bad + 1;
      if (fall_n < 16) adc_sdo = cur_word[15 - fall_n];
      fall_n = fall_n + 1;
      last_edge = $time;
    end
  end

  always @(posedge adc_sclk) begin
    if (in_frame) begin
      if (($time - last_edge) != DIV * CLK_PERIOD) hp_bad = hp_bad + 1;
      sdi_bits = {sdi_bits[14:0], adc_sdi};
      rise_n = rise_n + 1;
      last_edge = $time;
    end
  end

  always @(posedge adc_sync_n) begin
    if (in_frame) begin
      in_frame = 0;
      last_sync_rise = $time;
      if (nfr < 4) begin
        wlog[nfr] = cur_word;
        slog[nfr] = sdi_bits;
        rlog[nfr] = rise_n;
      end
      nfr = nfr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ctrl(input logic [1:0] pm, input logic [1:0] ch,
                                           input logic wbit);
    return {wbit, pm, ch, 7'b0};
  endfunction

  function automatic longint min_gap(input logic [7:0] g);
    return longint'(2 * DIV * ((g == 8'd0) ? 1 : int'(g)));
  endfunction

  task automatic run_req(input logic [1:0] pm, input logic [1:0] ch, input logic wr,
                         input logic [7:0] gap, input int hold);
    bit wake;
    int nexp;
    logic [1:0] c0;
    logic [11:0] d0;
    bit stable_ok;
    bit blocked_ok;
    logic [15:0] w;
    wake = !pm[1];
    nexp = wake ? 2 : 1;
    while (!req_ready) @(negedge clk);
    nfr = 0;
    cfg_pm = pm; cfg_chan = ch; cfg_write = wr; cfg_gap = gap;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble the configuration after acceptance
    cfg_pm = ~pm; cfg_chan = ~ch; cfg_write = ~wr; cfg_gap = 8'($urandom_range(0, 7));
    while (!res_valid) @(negedge clk);
    c0 = res_chan; d0 = res_data;
    stable_ok = 1; blocked_ok = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!res_valid || res_chan != c0 || res_data != d0) stable_ok = 0;
      if (req_ready) blocked_ok = 0;
    end
    check(stable_ok, "R8", "result held under back-pressure", longint'(stable_ok), 1);
    check(blocked_ok, "R8", "req_ready low while result pending", longint'(blocked_ok), 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid, "R8", "res_valid cleared after transfer", longint'(res_valid), 0);
    if (wake) check(nfr == nexp, "R3", "frames per request in auto mode", nfr, nexp);
    else      check(nfr == nexp, "R4", "frames per request in normal mode", nfr, nexp);
    if (nfr == nexp) begin
      w = wlog[nfr - 1];
      check(c0 == w[13:12], "R5", "channel id from returned word", c0, w[13:12]);
      check(d0 == w[11:0], "R6", "result from kept frame only", d0, w[11:0]);
      for (int f = 0; f < nexp; f++) begin
        logic [11:0] e;
        e = exp_ctrl(pm, ch, (wake && f == 0) ? 1'b0 : wr);
        if (wake && f == 0)
          check(slog[f][15:4] == e, "R3", "wake frame control word (R10 latched)", slog[f][15:4], e);
        else
          check(slog[f][15:4] == e, "R2", "control word (R10 latched)", slog[f][15:4], e);
        check(slog[f][3:0] == 4'b0, "R2", "data-in after control word", slog[f][3:0], 0);
        check(rlog[f] == 16, "R1", "clock rises per frame", rlog[f], 16);
      end
      if (nexp == 2)
        check(glog[1] >= min_gap(gap), "R7", "idle gap between frames", glog[1], min_gap(gap));
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(adc_sync_n == 1'b1, "R8", "reset frame-sync high", longint'(adc_sync_n), 1);
    check(adc_sclk == 1'b1, "R8", "reset serial clock high", longint'(adc_sclk), 1);
    check(res_valid == 1'b0, "R8", "reset res_valid low", longint'(res_valid), 0);
    check(req_ready == 1'b1, "R8", "reset req_ready high", longint'(req_ready), 1);

    // Directed: each power mode, zero gap, large gap, long back-pressure.
    run_req(2'b00, 2'd1, 1'b1, 8'd0, 0);
    run_req(2'b01, 2'd2, 1'b1, 8'd3, 5);
    run_req(2'b10, 2'd3, 1'b1, 8'd1, 2);
    run_req(2'b11, 2'd0, 1'b0, 8'd5, 0);
    run_req(2'b01, 2'd3, 1'b0, 8'd7, 12);

    for (int n = 0; n < 20; n++) begin
      run_req(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom_range(0, 6)),
              int'($urandom_range(0, 6)));
    end

    check(hp_bad == 0, "R9", "serial clock half-period violations", hp_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule